// File: doc/BRIEF.md
# Multiplexed Bus Splitter and Cycle Decoder

This block turns a 16-bit processor's shared address/data/status pins into a plain local bus. While the address latch enable is high, the address on the shared pins passes straight through to the address output. When the enable drops, the output keeps the last address captured at a clock edge. The same edge samples the three-bit status code. That code is decoded into a cycle type and into qualified read and write strobes. The byte-high-enable pin and address bit 0 are captured too and give two byte-lane enables and a refresh flag.

During an interrupt acknowledge, the top three shared pins carry the number of a cascaded slave controller instead of address bits. The block presents that number on a separate output. A one-clock pulse marks each point where the status leaves the idle code. A parameter selects an 8-bit-bus variant. In that variant, address bits 8 to 15 are not multiplexed, and the byte-high pin becomes an active-low refresh request.

Top module: `busDemux`

## Requirements
- R1: On reset, addrOut is 0 while aleIn is low, cycType is 3'b111, and rdStrobe, wrStrobe, laneLo, laneHi, refreshFlag, casValid and cycleStart are all 0.
- R2: While aleIn is high, addrOut equals {upperIn, adIn} combinationally. While aleIn is low, addrOut equals the value that was on those inputs at the last rising clock edge at which aleIn was high.
- R3: Status codes are: 3'b000 interrupt acknowledge, 3'b001 I/O read, 3'b010 I/O write, 3'b011 halt, 3'b100 instruction fetch, 3'b101 memory read, 3'b110 memory write, 3'b111 idle. At a clock edge where statIn is 3'b111, cycType becomes 3'b111. At any other edge with aleIn high, cycType takes statIn. Otherwise cycType holds its value.
- R4: rdStrobe is 1 exactly when cycType is 3'b001, 3'b100 or 3'b101 and refreshFlag is 0.
- R5: wrStrobe is 1 exactly when cycType is 3'b010 or 3'b110 and refreshFlag is 0.
- R6: Address bit 0 (adIn[0]) and bhenIn are captured at each clock edge with aleIn high. In a non-idle, non-halt, non-refresh cycle, the pair (a0, bhen) selects the lanes as follows: 00 gives both laneLo and laneHi; 01 gives laneLo only; 10 gives laneHi only.
- R7: With NARROW_BUS=0, a captured pair of 11 in a non-idle cycle raises refreshFlag. In that case laneLo, laneHi, rdStrobe and wrStrobe are all 0.
- R8: When an edge has aleIn high and statIn 3'b000, adIn[15:13] is captured. casAddr presents the captured value, and casValid is 1 while cycType is 3'b000.
- R9: cycleStart is 1 for the one clock that follows an edge at which statIn is not 3'b111 and the previous edge's statIn was 3'b111 (or the previous edge was in reset).
- R10: With NARROW_BUS=1, addrOut[15:8] always equals adIn[15:8]. laneHi is always 0. refreshFlag is 1 when the bhenIn captured at the last aleIn edge was 0 and cycType is not 3'b111. laneLo is 1 in any non-idle, non-halt, non-refresh cycle.
- R11: While cycType is 3'b011 (halt) or 3'b111 (idle), rdStrobe, wrStrobe, laneLo and laneHi are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aleIn | input | 1 | Address latch enable, active high |
| adIn | input | 16 | Shared address/data pins |
| upperIn | input | 3 | Address bits 18..16 (status in data phase) |
| statIn | input | 3 | Bus cycle status code |
| bhenIn | input | 1 | Active-low byte-high enable (refresh request in narrow variant) |
| addrOut | output | 19 | Demultiplexed address |
| cycType | output | 3 | Captured cycle type code |
| rdStrobe | output | 1 | Qualified read strobe |
| wrStrobe | output | 1 | Qualified write strobe |
| laneLo | output | 1 | Low byte lane enable |
| laneHi | output | 1 | High byte lane enable |
| refreshFlag | output | 1 | Refresh cycle indication |
| casAddr | output | 3 | Cascade slave number |
| casValid | output | 1 | Cascade number valid (interrupt acknowledge) |
| cycleStart | output | 1 | One-clock pulse on leaving idle status |

## Verification
The bench instantiates the block twice on the same stimulus: once with NARROW_BUS=0 and once with NARROW_BUS=1. The wide copy covers every combination of the a0/byte-high pair, including the refresh pair. The narrow copy covers the live upper address byte and the active-low refresh request. Both copies run directed cycles of every status code, and then a long stretch of random enable, status and pin values. The random stretch covers status changes without the enable, idle codes arriving mid-cycle, and back-to-back starts.

// File: rtl/busDemuxPkg.sv
package busDemuxPkg;

  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    CYC_INTA    = 3'b000,
    CYC_IORD    = 3'b001,
    CYC_IOWR    = 3'b010,
    CYC_HALT    = 3'b011,
    CYC_FETCH   = 3'b100,
    CYC_MEMRD   = 3'b101,
    CYC_MEMWR   = 3'b110,
    CYC_PASSIVE = 3'b111
  } cycCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;   // address phase: latch open
    logic capCas;    // address phase of an interrupt acknowledge
    logic busActive; // captured cycle is not idle
    logic haltCyc;   // captured cycle is a halt
  } ctrlStrobe_t;

endpackage

// File: rtl/busDemuxCtrl.sv
module busDemuxCtrl
  import busDemuxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleIn,
  input  logic [STAT_W-1:0] statIn,
  input  logic              refreshDet,
  output ctrlStrobe_t       strobes,
  output logic [STAT_W-1:0] cycType,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              casValid,
  output logic              cycleStart
);

  cycCode_e cycReg;
  cycCode_e statCode;
  logic     prevPassive;
  logic     startReg;

  assign statCode = cycCode_e'(statIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycReg      <= CYC_PASSIVE;
      prevPassive <= 1'b1;
      startReg    <= 1'b0;
    end else begin
      if (statCode == CYC_PASSIVE) begin
        cycReg <= CYC_PASSIVE;
      end else if (aleIn) begin
        cycReg <= statCode;
      end
      startReg    <= prevPassive && (statCode != CYC_PASSIVE);
      prevPassive <= (statCode == CYC_PASSIVE);
    end
  end

  always_comb begin
    strobes.capAddr   = aleIn;
    strobes.capCas    = aleIn && (statCode == CYC_INTA);
    strobes.busActive = (cycReg != CYC_PASSIVE);
    strobes.haltCyc   = (cycReg == CYC_HALT);
  end

  logic readType;
  logic writeType;

  always_comb begin
    readType  = 1'b0;
    writeType = 1'b0;
    case (cycReg)
      CYC_IORD, CYC_MEMRD, CYC_FETCH: readType  = 1'b1;
      CYC_IOWR, CYC_MEMWR:            writeType = 1'b1;
      default: ;
    endcase
  end

  assign rdStrobe   = readType && !refreshDet;
  assign wrStrobe   = writeType && !refreshDet;
  assign casValid   = (cycReg == CYC_INTA);
  assign cycType    = cycReg;
  assign cycleStart = startReg;

endmodule

// File: rtl/busDemuxPath.sv
module busDemuxPath
  import busDemuxPkg::*;
#(
  parameter int AD_W       = 16,
  parameter int ADDR_W     = 19,
  parameter int CAS_W      = 3,
  parameter bit NARROW_BUS = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobes,
  input  logic [AD_W-1:0]          adIn,
  input  logic [ADDR_W-AD_W-1:0]   upperIn,
  input  logic                     bhenIn,
  output logic [ADDR_W-1:0]        addrOut,
  output logic [CAS_W-1:0]         casAddr,
  output logic                     laneLo,
  output logic                     laneHi,
  output logic                     refreshDet
);

  localparam int BYTE_W = 8;
  localparam int UP_W   = ADDR_W - AD_W;
  localparam int MUX_W  = NARROW_BUS ? BYTE_W : AD_W;

  logic [MUX_W-1:0] heldLow;
  logic [UP_W-1:0]  heldUp;
  logic             a0Reg;
  logic             bheReg;
  logic [CAS_W-1:0] casReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldLow <= '0;
      heldUp  <= '0;
      a0Reg   <= 1'b1;
      bheReg  <= 1'b1;
      casReg  <= '0;
    end else begin
      if (strobes.capAddr) begin
        heldLow <= adIn[MUX_W-1:0];
        heldUp  <= upperIn;
        a0Reg   <= adIn[0];
        bheReg  <= bhenIn;
      end
      if (strobes.capCas) begin
        casReg <= adIn[AD_W-1 -: CAS_W];
      end
    end
  end

  logic [MUX_W-1:0] lowMux;
  logic [UP_W-1:0]  upMux;

  assign lowMux = strobes.capAddr ? adIn[MUX_W-1:0] : heldLow;
  assign upMux  = strobes.capAddr ? upperIn : heldUp;

  logic laneGate;

  generate
    if (NARROW_BUS) begin : g_narrow
      assign addrOut    = {upMux, adIn[AD_W-1:MUX_W], lowMux};
      assign refreshDet = strobes.busActive && !bheReg;
      assign laneGate   = strobes.busActive && !strobes.haltCyc && !refreshDet;
      assign laneLo     = laneGate;
      assign laneHi     = 1'b0;
    end else begin : g_wide
      assign addrOut    = {upMux, lowMux};
      assign refreshDet = strobes.busActive && a0Reg && bheReg;
      assign laneGate   = strobes.busActive && !strobes.haltCyc && !refreshDet;
      assign laneLo     = laneGate && !a0Reg;
      assign laneHi     = laneGate && !bheReg;
    end
  endgenerate

  assign casAddr = casReg;

endmodule

// File: rtl/busDemux.sv
module busDemux
  import busDemuxPkg::*;
#(
  parameter int AD_W       = 16,
  parameter int ADDR_W     = 19,
  parameter int CAS_W      = 3,
  parameter bit NARROW_BUS = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   aleIn,
  input  logic [AD_W-1:0]        adIn,
  input  logic [ADDR_W-AD_W-1:0] upperIn,
  input  logic [STAT_W-1:0]      statIn,
  input  logic                   bhenIn,
  output logic [ADDR_W-1:0]      addrOut,
  output logic [STAT_W-1:0]      cycType,
  output logic                   rdStrobe,
  output logic                   wrStrobe,
  output logic                   laneLo,
  output logic                   laneHi,
  output logic                   refreshFlag,
  output logic [CAS_W-1:0]       casAddr,
  output logic                   casValid,
  output logic                   cycleStart
);

  ctrlStrobe_t strobes;
  logic        refreshDet;

  busDemuxCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .aleIn      (aleIn),
    .statIn     (statIn),
    .refreshDet (refreshDet),
    .strobes    (strobes),
    .cycType    (cycType),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe),
    .casValid   (casValid),
    .cycleStart (cycleStart)
  );

  busDemuxPath #(
    .AD_W       (AD_W),
    .ADDR_W     (ADDR_W),
    .CAS_W      (CAS_W),
    .NARROW_BUS (NARROW_BUS)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .adIn       (adIn),
    .upperIn    (upperIn),
    .bhenIn     (bhenIn),
    .addrOut    (addrOut),
    .casAddr    (casAddr),
    .laneLo     (laneLo),
    .laneHi     (laneHi),
    .refreshDet (refreshDet)
  );

  assign refreshFlag = refreshDet;

endmodule

// File: rtl/busDemuxChecker.sv
module busDemuxChecker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              aleIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic [2:0]        cycType,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic              laneLo,
  input logic              laneHi,
  input logic              refreshFlag,
  input logic              casValid,
  input logic              cycleStart
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cycType == 3'b111 && !rdStrobe && !wrStrobe && !cycleStart)); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!aleIn && !$past(aleIn)) |-> (addrOut[7:0] == $past(addrOut[7:0]))); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cycType == 3'b111) |-> !(rdStrobe || wrStrobe || laneLo || laneHi || refreshFlag)); // R3

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe)); // R4

  AST_REFRESH_NO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    refreshFlag |-> !(laneLo || laneHi || rdStrobe || wrStrobe)); // R7

  AST_CAS_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    casValid |-> !(rdStrobe || wrStrobe)); // R8

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart); // R9

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cycType == 3'b011) |-> !(rdStrobe || wrStrobe || laneLo || laneHi)); // R11

endmodule

bind busDemux busDemuxChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .aleIn       (aleIn),
  .addrOut     (addrOut),
  .cycType     (cycType),
  .rdStrobe    (rdStrobe),
  .wrStrobe    (wrStrobe),
  .laneLo      (laneLo),
  .laneHi      (laneHi),
  .refreshFlag (refreshFlag),
  .casValid    (casValid),
  .cycleStart  (cycleStart)
);

// File: tb/busDemux_bench.sv
module busDemux_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam real PERIOD = 10.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aleIn = 1'b0;
  logic [15:0] adIn = '0;
  logic [2:0]  upperIn = '0;
  logic [2:0]  statIn = 3'b111;
  logic        bhenIn = 1'b1;

  logic [18:0] wAddr, nAddr;
  logic [2:0]  wCyc, nCyc, wCas, nCas;
  logic        wRd, wWr, wLo, wHi, wRf, wCv, wCs;
  logic        nRd, nWr, nLo, nHi, nRf, nCv, nCs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(PERIOD / 2) clk = ~clk;

  busDemux #(.NARROW_BUS(1'b0)) u_busDemux (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .adIn(adIn), .upperIn(upperIn),
    .statIn(statIn), .bhenIn(bhenIn), .addrOut(wAddr), .cycType(wCyc),
    .rdStrobe(wRd), .wrStrobe(wWr), .laneLo(wLo), .laneHi(wHi),
    .refreshFlag(wRf), .casAddr(wCas), .casValid(wCv), .cycleStart(wCs));

  busDemux #(.NARROW_BUS(1'b1)) u_busDemux_narrow (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .adIn(adIn), .upperIn(upperIn),
    .statIn(statIn), .bhenIn(bhenIn), .addrOut(nAddr), .cycType(nCyc),
    .rdStrobe(nRd), .wrStrobe(nWr), .laneLo(nLo), .laneHi(nHi),
    .refreshFlag(nRf), .casAddr(nCas), .casValid(nCv), .cycleStart(nCs));

  // behavioural reference state
  int mHeld, mCyc, mA0, mBhe, mCas, mStart, mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHeld <= 0; mCyc <= 7; mA0 <= 1; mBhe <= 1; mCas <= 0; mStart <= 0; mPrev <= 7;
    end else begin
      if (aleIn) begin
        mHeld <= {upperIn, adIn};
        mA0   <= adIn[0];
        mBhe  <= bhenIn;
        if (statIn == 0) mCas <= adIn[15:13];
      end
      if (statIn == 7) mCyc <= 7;
      else if (aleIn) mCyc <= statIn;
      mStart <= (mPrev == 7 && statIn != 7) ? 1 : 0;
      mPrev  <= statIn;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareOne(input bit nar, input logic [18:0] a, input logic [2:0] ct,
                            input logic rd, input logic wr, input logic lo, input logic hi,
                            input logic rf, input logic [2:0] ca, input logic cv,
                            input logic cs);
    int expA, act, eRf, eLo, eHi, eRd, eWr, gate;
    string rq;
    act  = (mCyc != 7) ? 1 : 0;
    expA = aleIn ? int'({upperIn, adIn}) : mHeld;
    if (nar) begin
      expA = (expA & 32'h70_0FF) | (int'(adIn[15:8]) << 8);
      eRf  = (act && !mBhe) ? 1 : 0;
    end else begin
      eRf  = (act && mA0 && mBhe) ? 1 : 0;
    end
    gate = (act && mCyc != 3 && !eRf) ? 1 : 0;
    eLo  = nar ? gate : (gate && !mA0) ? 1 : 0;
    eHi  = nar ? 0 : (gate && !mBhe) ? 1 : 0;
    eRd  = ((mCyc == 1 || mCyc == 4 || mCyc == 5) && !eRf) ? 1 : 0;
    eWr  = ((mCyc == 2 || mCyc == 6) && !eRf) ? 1 : 0;
    chk(int'(a) == expA, nar ? "R10" : "R2", "addrOut", a, expA);
    chk(int'(ct) == mCyc, "R3", "cycType", ct, mCyc);
    chk(int'(rd) == eRd, "R4", "rdStrobe", rd, eRd);
    chk(int'(wr) == eWr, "R5", "wrStrobe", wr, eWr);
    rq = nar ? "R10" : (mCyc == 3 ? "R11" : "R6");
    chk(int'(lo) == eLo, rq, "laneLo", lo, eLo);
    chk(int'(hi) == eHi, rq, "laneHi", hi, eHi);
    chk(int'(rf) == eRf, nar ? "R10" : "R7", "refreshFlag", rf, eRf);
    chk(int'(cv) == ((mCyc == 0) ? 1 : 0), "R8", "casValid", cv, mCyc == 0);
    if (mCyc == 0) chk(int'(ca) == mCas, "R8", "casAddr", ca, mCas);
    chk(int'(cs) == mStart, "R9", "cycleStart", cs, mStart);
  endtask

  always @(negedge clk) begin
    compareOne(1'b0, wAddr, wCyc, wRd, wWr, wLo, wHi, wRf, wCas, wCv, wCs);
    compareOne(1'b1, nAddr, nCyc, nRd, nWr, nLo, nHi, nRf, nCas, nCv, nCs);
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic drive(input bit ale, input logic [15:0] ad, input logic [2:0] up,
                       input logic [2:0] st, input bit bhe);
    @(posedge clk);
    #(PERIOD / 4);
    aleIn = ale; adIn = ad; upperIn = up; statIn = st; bhenIn = bhe;
  endtask

  task automatic busCycle(input logic [2:0] st, input logic [18:0] addr,
                          input bit bhe, input logic [15:0] data);
    drive(1'b1, addr[15:0], addr[18:16], st, bhe);
    drive(1'b0, data, 3'b000, st, bhe);
    drive(1'b0, ~data, 3'b000, st, bhe);
    drive(1'b0, 16'hFFFF, 3'b000, 3'b111, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD / 4);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state observed at the ports
    chk(wAddr == 0 && nAddr == 0, "R1", "addrOut", wAddr, 0);
    chk(wCyc == 3'b111, "R1", "cycType", wCyc, 7);
    chk({wRd, wWr, wLo, wHi, wRf, wCv, wCs} == 0, "R1", "strobes",
        {wRd, wWr, wLo, wHi, wRf, wCv, wCs}, 0);

    busCycle(3'b101, 19'h5_1234, 1'b0, 16'hA5A5); // memory read, word
    busCycle(3'b110, 19'h2_0031, 1'b0, 16'h1111); // memory write, odd byte
    busCycle(3'b001, 19'h0_0302, 1'b1, 16'h2222); // I/O read, even byte
    busCycle(3'b010, 19'h0_0400, 1'b0, 16'h3333); // I/O write, word
    busCycle(3'b100, 19'h7_FFFE, 1'b0, 16'h4444); // fetch
    busCycle(3'b011, 19'h1_0000, 1'b0, 16'h0000); // halt, R11
    busCycle(3'b000, 19'h0_A000, 1'b1, 16'h00FF); // interrupt acknowledge, cascade 5
    busCycle(3'b000, 19'h0_E000, 1'b0, 16'h00FF); // cascade 7
    busCycle(3'b101, 19'h3_0001, 1'b1, 16'h5555); // refresh pair 11
    busCycle(3'b101, 19'h3_0000, 1'b1, 16'h5555); // narrow variant refresh pin low? no: bhen high
    busCycle(3'b101, 19'h3_0000, 1'b0, 16'h5555);
    // status leaves idle without the enable: start pulse, type stays idle
    drive(1'b0, 16'h0000, 3'b000, 3'b101, 1'b1);
    drive(1'b0, 16'h0000, 3'b000, 3'b101, 1'b1);
    drive(1'b0, 16'h0000, 3'b000, 3'b111, 1'b1);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] & r[1], r[31:16], r[4:2], (r[7:5] == 3'b000 && r[8]) ? 3'b111 : r[7:5], r[9]);
    end
    drive(1'b0, 16'h0000, 3'b000, 3'b111, 1'b1);
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule